// File: doc/BRIEF.md
# Floating-Point Min/Max Selection Unit

This unit takes two floating-point operands and returns the smaller or the larger of them. Which of several standard definitions of "smaller" and "larger" applies is chosen per operation by a 4-bit operation code. The definitions differ in three ways: how NaN inputs are treated, whether negative zero orders below positive zero, and which operand wins when the comparison is false. The unit handles 32-bit and 64-bit operands, selected by one format bit. An operation also produces an invalid-operation flag.

The result is always one of the two operands or the canonical quiet NaN of the selected format. Each magnitude form compares absolute values. When the magnitudes tie or a NaN is present, it falls back to the matching signed form of the same family and direction. A single register stage sits between the inputs and the outputs. A valid strobe travels through that stage next to the data, so the unit can accept a new operation on every clock.

Top module: `fpMinMaxUnit`

## Requirements
- R1: `opSel` is decoded as follows. Bit 0 selects max (1) or min (0). Bits 2:1 select the family: 00 = 2008 minNum/maxNum, 01 = 2019 minimum/maximum, 10 = 2019 minimumNumber/maximumNumber, 11 = C ternary. Bit 3 selects the magnitude form of that family.
- R2: `validOut`, `result` and `invalidOut` reflect an operation on the clock edge after the edge that sampled it with `validIn` high. `validOut` is low one clock after a cycle with `validIn` low.
- R3: In family 00, a quiet NaN in one operand returns the other operand. Two NaNs, or a signaling NaN in either operand, return a quiet NaN. -0.0 orders strictly below +0.0.
- R4: In family 01, a NaN in either operand returns a quiet NaN, and -0.0 orders below +0.0.
- R5: In family 10, exactly one NaN (quiet or signaling) returns the non-NaN operand. Two NaNs return a quiet NaN. -0.0 orders below +0.0.
- R6: In family 11, min returns A when A < B and otherwise B, and max returns A when A > B and otherwise B. The comparison treats -0.0 and +0.0 as equal, and any NaN makes it false.
- R7: A magnitude form with unequal magnitudes and no NaN returns, for min, the operand of smaller absolute value. For max it returns the operand of larger absolute value.
- R8: A magnitude form with equal magnitudes, or with any NaN operand, returns exactly what the same family and direction would return without bit 3 set.
- R9: `invalidOut` is high for an operation exactly when either operand, in the selected format, is a signaling NaN (all-ones exponent, non-zero fraction, top fraction bit clear). It is never high without `validOut`.
- R10: Every NaN result is the canonical quiet NaN: 0x7FC00000 in 32-bit mode, 0x7FF8000000000000 in 64-bit mode. Every other result equals one of the two operands bit for bit.
- R11: With `isDouble` low, only bits 31:0 of each operand are used, bits 63:32 of the inputs have no effect, and bits 63:32 of `result` are zero.
- R12: After reset, `validOut`, `invalidOut` and `result` are all zero until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands and opcode are valid this cycle |
| isDouble | input | 1 | 1 = 64-bit format, 0 = 32-bit format in bits 31:0 |
| opSel | input | 4 | Operation code, see R1 |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| validOut | output | 1 | Result and flag are valid |
| result | output | 64 | Selected operand or canonical quiet NaN |
| invalidOut | output | 1 | Signaling-NaN input seen for this result |

## Verification
Most internal faults show up at the ports on the very next clock, because there is only one register stage. A wrongly decoded family or direction returns the other operand, or a NaN where a number was expected. A broken sign-of-zero ordering only shows when the operands are ±0.0. A broken NaN classifier shows as a non-canonical NaN, a missing or spurious flag, or a lost numeric operand. Corner cases are therefore driven directly: signed zeros, equal magnitudes, quiet and signaling NaNs on each side, and dirty upper bits in 32-bit mode. Random operands drawn from a pool of these values cover the remaining combinations.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  localparam int DataW   = 64;
  localparam int SingleW = 32;
  localparam int OpW     = 4;

  localparam int DblExpW  = 11;
  localparam int DblFracW = 52;
  localparam int SglExpW  = 8;
  localparam int SglFracW = 23;

  localparam logic [DataW-1:0] CanonNanDbl = 64'h7FF8_0000_0000_0000;
  localparam logic [DataW-1:0] CanonNanSgl = 64'h0000_0000_7FC0_0000;

  typedef enum logic [1:0] {
    FAM_NUM08 = 2'b00,
    FAM_MIN19 = 2'b01,
    FAM_NUM19 = 2'b10,
    FAM_CTERN = 2'b11
  } fpmmFamily_t;

  typedef struct packed {
    logic        capture;
    logic        isMax;
    logic        useMag;
    fpmmFamily_t family;
    logic        dbl;
  } fpmmStrobe_t;

  typedef struct packed {
    logic             sign;
    logic             isNan;
    logic             isSnan;
    logic             isZero;
    logic [DataW-2:0] mag;
  } fpmmClass_t;

endpackage

// File: rtl/fpmmClassify.sv
module fpmmClassify
  import fpmm_pkg::*;
(
  input  logic             dbl,
  input  logic [DataW-1:0] operand,
  output fpmmClass_t       cls
);

  logic [DblExpW-1:0]  dExp;
  logic [DblFracW-1:0] dFrac;
  logic [SglExpW-1:0]  sExp;
  logic [SglFracW-1:0] sFrac;
  logic                expOnes;
  logic                fracZero;
  logic                quietBit;

  assign dExp  = operand[DataW-2 -: DblExpW];
  assign dFrac = operand[DblFracW-1:0];
  assign sExp  = operand[SingleW-2 -: SglExpW];
  assign sFrac = operand[SglFracW-1:0];

  always_comb begin
    if (dbl) begin
      expOnes  = &dExp;
      fracZero = ~|dFrac;
      quietBit = dFrac[DblFracW-1];
      cls.sign = operand[DataW-1];
      cls.mag  = operand[DataW-2:0];
      cls.isZero = ~|dExp & fracZero;
    end else begin
      expOnes  = &sExp;
      fracZero = ~|sFrac;
      quietBit = sFrac[SglFracW-1];
      cls.sign = operand[SingleW-1];
      cls.mag  = {{(DataW-SingleW){1'b0}}, operand[SingleW-2:0]};
      cls.isZero = ~|sExp & fracZero;
    end
    cls.isNan  = expOnes & ~fracZero;
    cls.isSnan = expOnes & ~fracZero & ~quietBit;
  end

endmodule

// File: rtl/fpmmControl.sv
module fpmmControl
  import fpmm_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           validIn,
  input  logic           isDouble,
  input  logic [OpW-1:0] opSel,
  output fpmmStrobe_t    strobe,
  output logic           validQ
);

  always_comb begin
    strobe.capture = validIn;
    strobe.isMax   = opSel[0];
    strobe.family  = fpmmFamily_t'(opSel[2:1]);
    strobe.useMag  = opSel[3];
    strobe.dbl     = isDouble;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= validIn;
  end

endmodule

// File: rtl/fpmmDatapath.sv
module fpmmDatapath
  import fpmm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fpmmStrobe_t      strobe,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  output logic [DataW-1:0] resultQ,
  output logic             invalidQ
);

  localparam int NumOps = 2;

  logic [DataW-1:0] opnd [NumOps];
  fpmmClass_t       cls  [NumOps];
  fpmmClass_t       ca, cb;

  assign opnd[0] = opA;
  assign opnd[1] = opB;

  for (genvar g = 0; g < NumOps; g++) begin : gClass
    fpmmClassify classify_i (
      .dbl    (strobe.dbl),
      .operand(opnd[g]),
      .cls    (cls[g])
    );
  end

  assign ca = cls[0];
  assign cb = cls[1];

  logic magLt, magGt, magEq;
  logic anyNan, bothNan, anySnan, bothZero;
  logic signedLt, signedGt, realLt, realGt;
  logic pickB, forceNan, baseB, baseNan, selNan;
  logic [DataW-1:0] chosen, masked, canon;

  assign magLt    = ca.mag < cb.mag;
  assign magGt    = ca.mag > cb.mag;
  assign magEq    = ca.mag == cb.mag;
  assign anyNan   = ca.isNan | cb.isNan;
  assign bothNan  = ca.isNan & cb.isNan;
  assign anySnan  = ca.isSnan | cb.isSnan;
  assign bothZero = ca.isZero & cb.isZero;

  // ordering with -0 strictly below +0 (operands assumed non-NaN)
  assign signedLt = (ca.sign & ~cb.sign)
                  | (~ca.sign & ~cb.sign & magLt)
                  | (ca.sign & cb.sign & magGt);
  assign signedGt = (~ca.sign & cb.sign)
                  | (~ca.sign & ~cb.sign & magGt)
                  | (ca.sign & cb.sign & magLt);
  // plain numeric ordering: zeros equal, NaN unordered
  assign realLt = ~anyNan & ~bothZero & signedLt;
  assign realGt = ~anyNan & ~bothZero & signedGt;

  always_comb begin
    baseNan = 1'b0;
    baseB   = strobe.isMax ? ~signedGt : ~signedLt;
    unique case (strobe.family)
      FAM_NUM08: begin
        baseNan = anySnan | bothNan;
        if (ca.isNan)      baseB = 1'b1;
        else if (cb.isNan) baseB = 1'b0;
      end
      FAM_MIN19: begin
        baseNan = anyNan;
      end
      FAM_NUM19: begin
        baseNan = bothNan;
        if (ca.isNan)      baseB = 1'b1;
        else if (cb.isNan) baseB = 1'b0;
      end
      FAM_CTERN: begin
        baseB = strobe.isMax ? ~realGt : ~realLt;
      end
      default: ;
    endcase
  end

  always_comb begin
    pickB    = baseB;
    forceNan = baseNan;
    if (strobe.useMag && !anyNan && !magEq) begin
      pickB    = strobe.isMax ? ~magGt : ~magLt;
      forceNan = 1'b0;
    end
  end

  assign selNan = pickB ? cb.isNan : ca.isNan;
  assign chosen = pickB ? opB : opA;
  assign masked = strobe.dbl ? chosen
                             : {{(DataW-SingleW){1'b0}}, chosen[SingleW-1:0]};
  assign canon  = strobe.dbl ? CanonNanDbl : CanonNanSgl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ  <= '0;
      invalidQ <= 1'b0;
    end else begin
      invalidQ <= strobe.capture & anySnan;
      if (strobe.capture) resultQ <= (forceNan | selNan) ? canon : masked;
    end
  end

endmodule

// File: rtl/fpMinMaxUnit.sv
module fpMinMaxUnit
  import fpmm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic             isDouble,
  input  logic [OpW-1:0]   opSel,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  output logic             validOut,
  output logic [DataW-1:0] result,
  output logic             invalidOut
);

  fpmmStrobe_t strobe;

  fpmmControl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .isDouble(isDouble),
    .opSel   (opSel),
    .strobe  (strobe),
    .validQ  (validOut)
  );

  fpmmDatapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .resultQ (result),
    .invalidQ(invalidOut)
  );

endmodule

// File: rtl/fpmmChecker.sv
module fpmmChecker
  import fpmm_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             validIn,
  input logic             isDouble,
  input logic [OpW-1:0]   opSel,
  input logic [DataW-1:0] opA,
  input logic [DataW-1:0] opB,
  input logic             validOut,
  input logic [DataW-1:0] result,
  input logic             invalidOut
);

  function automatic logic sigNan(logic [DataW-1:0] x, logic d);
    if (d) return (&x[62:52]) && (|x[50:0]) && !x[51];
    return (&x[30:23]) && (|x[21:0]) && !x[22];
  endfunction

  function automatic logic [DataW-1:0] lowPart(logic [DataW-1:0] x, logic d);
    return d ? x : {32'b0, x[31:0]};
  endfunction

  logic inSnan;
  assign inSnan = sigNan(opA, isDouble) | sigNan(opB, isDouble);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);  // R2
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && inSnan) |=> invalidOut);  // R9
  AST_NO_SNAN_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !inSnan) |=> !invalidOut);  // R9
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    invalidOut |-> validOut);  // R9
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !isDouble) |=> (result[63:32] == 32'b0));  // R11
  AST_RESULT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> (result == lowPart($past(opA), $past(isDouble))
              || result == lowPart($past(opB), $past(isDouble))
              || result == ($past(isDouble) ? CanonNanDbl : CanonNanSgl)));  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(result));  // R2

endmodule

bind fpMinMaxUnit fpmmChecker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .isDouble  (isDouble),
  .opSel     (opSel),
  .opA       (opA),
  .opB       (opB),
  .validOut  (validOut),
  .result    (result),
  .invalidOut(invalidOut)
);

// File: tb/fpMinMaxUnit_tb_top.sv
module fpMinMaxUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic        isDouble = 1'b0;
  logic [3:0]  opSel = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        validOut;
  logic [63:0] result;
  logic        invalidOut;

  int checkCount = 0;
  int failCount = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  fpMinMaxUnit dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .isDouble(isDouble),
    .opSel(opSel), .opA(opA), .opB(opB), .validOut(validOut),
    .result(result), .invalidOut(invalidOut)
  );

  localparam logic [63:0] D_PZ = 64'h0, D_NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] D_TWO = 64'h4000_0000_0000_0000, D_MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] D_QN = 64'h7FF8_0000_0000_0001, D_SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] D_INF = 64'h7FF0_0000_0000_0000;
  localparam logic [31:0] S_ONE = 32'h3F80_0000, S_MONE = 32'hBF80_0000, S_TWO = 32'h4000_0000;
  localparam logic [31:0] S_QN = 32'h7FC0_0001, S_SN = 32'h7F80_0001, S_NZ = 32'h8000_0000;

  function automatic logic [63:0] norm(logic [63:0] x, bit d);
    return d ? x : {32'b0, x[31:0]};
  endfunction
  function automatic bit nanOf(logic [63:0] x, bit d);
    return d ? (x[62:52] == 11'h7FF && x[51:0] != 0) : (x[30:23] == 8'hFF && x[22:0] != 0);
  endfunction
  function automatic bit snanOf(logic [63:0] x, bit d);
    return nanOf(x, d) && !(d ? x[51] : x[22]);
  endfunction
  function automatic logic [63:0] absOf(logic [63:0] x, bit d);
    return d ? {1'b0, x[62:0]} : {33'b0, x[30:0]};
  endfunction
  function automatic logic [63:0] orderKey(logic [63:0] x, bit d);
    if (d) return x[63] ? ~x : {1'b1, x[62:0]};
    return x[31] ? {32'b0, ~x[31:0]} : {32'b0, 1'b1, x[30:0]};
  endfunction

  // expected {flag, result} from the requirements
  function automatic logic [64:0] model(logic [63:0] a0, logic [63:0] b0, logic [3:0] op, bit d);
    logic [63:0] a, b, r, ka, kb, ma, mb;
    bit an, bn, nanRes, lt, gt, zz;
    a = norm(a0, d); b = norm(b0, d);
    an = nanOf(a, d); bn = nanOf(b, d);
    ka = orderKey(a, d); kb = orderKey(b, d);
    ma = absOf(a, d); mb = absOf(b, d);
    zz = (ma == 0) && (mb == 0);
    nanRes = 0;
    lt = ka < kb; gt = ka > kb;
    case (op[2:1])
      2'b00: begin
        if (snanOf(a, d) || snanOf(b, d) || (an && bn)) nanRes = 1;
        else if (an) r = b;
        else if (bn) r = a;
        else r = op[0] ? (gt ? a : b) : (lt ? a : b);
      end
      2'b01: begin
        if (an || bn) nanRes = 1;
        else r = op[0] ? (gt ? a : b) : (lt ? a : b);
      end
      2'b10: begin
        if (an && bn) nanRes = 1;
        else if (an) r = b;
        else if (bn) r = a;
        else r = op[0] ? (gt ? a : b) : (lt ? a : b);
      end
      default: begin
        if (an || bn || zz) r = b;
        else r = op[0] ? (gt ? a : b) : (lt ? a : b);
      end
    endcase
    if (op[3] && !an && !bn && ma != mb) begin
      nanRes = 0;
      r = op[0] ? ((ma > mb) ? a : b) : ((ma < mb) ? a : b);
    end
    if (nanRes || nanOf(r, d)) r = d ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
    return {snanOf(a, d) | snanOf(b, d), r};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(string tag, logic [63:0] a, logic [63:0] b, logic [3:0] op, bit d);
    logic [64:0] exp;
    exp = model(a, b, op, d);
    @(negedge clk);
    validIn = 1; opA = a; opB = b; opSel = op; isDouble = d;
    @(negedge clk);
    validIn = 0;
    check({tag, " R2 valid"}, {63'b0, validOut}, 64'd1);
    check({tag, " result"}, result, exp[63:0]);
    check({tag, " R9 flag"}, {63'b0, invalidOut}, {63'b0, exp[64]});
  endtask

  function automatic logic [3:0] opc(logic [1:0] fam, bit mx, bit mg);
    return {mg, fam, mx};
  endfunction

  function automatic logic [63:0] poolVal(bit d);
    logic [63:0] v;
    int unsigned s;
    s = $urandom % 10;
    case (s)
      0: v = D_PZ; 1: v = D_NZ; 2: v = D_QN; 3: v = D_SN; 4: v = D_INF;
      5: v = D_ONE; 6: v = D_MONE;
      default: v = {$urandom, $urandom};
    endcase
    if (!d) begin
      case (s)
        1: v = {$urandom, S_NZ}; 2: v = {$urandom, S_QN}; 3: v = {$urandom, S_SN};
        5: v = {$urandom, S_ONE}; 6: v = {$urandom, S_MONE};
        default: v = {$urandom, v[63:32] ^ v[31:0]};
      endcase
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      failCount++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 validOut", {63'b0, validOut}, 64'd0);
    check("R12 flag", {63'b0, invalidOut}, 64'd0);
    check("R12 result", result, 64'd0);
    rstN = 1;
    @(negedge clk);
    check("R12 after release", result, 64'd0);

    // R1 opcode decode: min/max direction
    runOp("R1 min08", D_ONE, D_TWO, opc(2'b00, 0, 0), 1);
    runOp("R1 max08", D_ONE, D_TWO, opc(2'b00, 1, 0), 1);
    // R3 2008 family
    runOp("R3 qnanA", D_QN, D_TWO, opc(2'b00, 0, 0), 1);
    runOp("R3 qnanB", D_MONE, D_QN, opc(2'b00, 1, 0), 1);
    runOp("R3 snan", D_SN, D_ONE, opc(2'b00, 0, 0), 1);
    runOp("R3 zeros min", D_PZ, D_NZ, opc(2'b00, 0, 0), 1);
    runOp("R3 zeros max", D_NZ, D_PZ, opc(2'b00, 1, 0), 1);
    // R4 2019 minimum/maximum
    runOp("R4 nan", D_ONE, D_QN, opc(2'b01, 0, 0), 1);
    runOp("R4 zeros", D_PZ, D_NZ, opc(2'b01, 0, 0), 1);
    runOp("R4 max", D_MTWO, D_MONE, opc(2'b01, 1, 0), 1);
    // R5 2019 Number
    runOp("R5 one snan", D_SN, D_MTWO, opc(2'b10, 0, 0), 1);
    runOp("R5 both nan", D_QN, D_SN, opc(2'b10, 1, 0), 1);
    runOp("R5 zeros", D_NZ, D_PZ, opc(2'b10, 1, 0), 1);
    // R6 C ternary
    runOp("R6 equal zeros", D_NZ, D_PZ, opc(2'b11, 0, 0), 1);
    runOp("R6 nanB", D_ONE, D_QN, opc(2'b11, 1, 0), 1);
    runOp("R6 nanA", D_QN, D_ONE, opc(2'b11, 0, 0), 1);
    runOp("R6 lt", D_MONE, D_ONE, opc(2'b11, 0, 0), 1);
    // R7 magnitude
    runOp("R7 minmag", D_MTWO, D_ONE, opc(2'b01, 0, 1), 1);
    runOp("R7 maxmag", D_MTWO, D_ONE, opc(2'b11, 1, 1), 1);
    // R8 magnitude fallback
    runOp("R8 tie", D_MONE, D_ONE, opc(2'b01, 1, 1), 1);
    runOp("R8 tie C", D_ONE, D_MONE, opc(2'b11, 0, 1), 1);
    runOp("R8 nan", D_QN, D_TWO, opc(2'b00, 1, 1), 1);
    // R10 canonical NaN, R11 single format with dirty upper bits
    runOp("R10 sgl nan", {32'hDEAD_BEEF, S_QN}, {32'h1234_5678, S_ONE}, opc(2'b01, 0, 0), 0);
    runOp("R11 sgl min", {32'hFFFF_FFFF, S_TWO}, {32'hAAAA_AAAA, S_MONE}, opc(2'b00, 0, 0), 0);
    runOp("R11 sgl snan", {32'h0, S_SN}, {32'h7FF0_0000, S_NZ}, opc(2'b10, 1, 0), 0);
    runOp("R11 upper snan ignored", {32'h7FF0_0000, S_ONE}, {32'h0000_0001, S_TWO}, opc(2'b00, 1, 0), 0);
    // R2 idle cycle: validOut drops
    @(negedge clk);
    check("R2 idle", {63'b0, validOut}, 64'd0);

    // random mix, back-to-back issue
    for (int i = 0; i < 600; i++) begin
      bit d;
      logic [63:0] a, b;
      logic [3:0] op;
      d = $urandom % 2;
      a = poolVal(d);
      b = ($urandom % 4 == 0) ? (a ^ (d ? 64'h8000_0000_0000_0000 : 64'h8000_0000)) : poolVal(d);
      op = 4'($urandom);
      runOp("R1 random", a, b, op, d);
    end

    doneFlag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule